// File: doc/BRIEF.md
# Glitch-Free Single-Channel PWM Generator

This block drives one pulse-width-modulated output from a free-running counter. Software reaches it through a plain 32-bit register port. The port has four word registers: the live count, the period length, the duty length and a control word. Period and duty are counts of input clock cycles, with no prescaling. To get a period in nanoseconds, program clock_hz × ns / 1e9 cycles. Each period begins with the duty phase, which lasts `duty` cycles, and ends with the off phase.

Software changes the waveform as follows. It sets the lock bit in the control word, rewrites period, duty and the two polarity fields, and then clears the lock. While the lock is set, the running waveform is untouched. After the lock clears, all staged values move into the timing engine together, on the cycle that starts the next period. A period that mixes old and new settings is therefore never produced. While the channel is not running, the staged values are taken on every unlocked cycle.

Top module: `pwm_locked_top`

## Requirements
- R1: After reset the output is high, the control word reads 0x18 (both polarity fields positive, everything else clear), and period, duty and count read 0.
- R2: Byte offsets are 0x00 for the count, 0x04 for the period, 0x08 for the duty and 0x0C for the control word. Period and duty read back the last written (staged) values. The control word reads back only its defined bits (mask 0x17F). A read returns the register selected in the previous cycle.
- R3: While control bit 6 (lock) is set, writes to the period, duty and polarity do not change the output waveform or the counter's wrap point.
- R4: Once the lock is clear, staged period, duty and polarity become active together on the cycle where the counter wraps to 0, never in mid-period. The count read back keeps wrapping at the old period − 1 until that wrap.
- R5: While running with period P > 0, the count steps 0, 1, …, P−1 and repeats. The output is in the duty phase while the count is below the duty value and in the off phase otherwise. The count register reads the live count, and writes to it are ignored.
- R6: A duty of 0 gives a constant off-phase level. A duty of P or more gives a constant duty-phase level. A period of 0 holds the output at the inactive level.
- R7: Control bit 3 set drives the duty phase high and bit 4 set drives the inactive level high. The off phase is the complement of the duty phase.
- R8: The channel runs only when bit 0 = 1, bits 2:1 = 01 (continuous), bit 5 = 0 (left-aligned) and bit 8 = 1 (low-power disable). Any other setting holds the count at 0 and drives the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The assertions check on every cycle that the active settings stay frozen while the lock is held. They also check that the active settings change only on a wrap of a running counter, that the count stays below the active period, and that an idle channel sits at its inactive level with the count at 0. The constant-level cases for duty 0 and for a duty at or above the period are checked on every cycle as well. Other behaviour is shown only by the bench's scenarios: the duty-phase share of the waveform for each polarity pairing, the register offsets and readback masking, the ignored count write, and the exact wrap points before and after an unlock.

// File: rtl/pwm_lk_pkg.sv
package pwm_lk_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFF_COUNT  = 4'h0;
  localparam logic [3:0] OFF_PERIOD = 4'h4;
  localparam logic [3:0] OFF_DUTY   = 4'h8;
  localparam logic [3:0] OFF_CTRL   = 4'hC;

  localparam int B_EN     = 0;
  localparam int B_MODE_L = 1;
  localparam int B_DPOL   = 3;
  localparam int B_IPOL   = 4;
  localparam int B_ALIGN  = 5;
  localparam int B_LOCK   = 6;
  localparam int B_LPDIS  = 8;

  localparam logic [1:0] MODE_CONT = 2'b01;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h0000_017F;
  localparam logic [DATA_W-1:0] CTRL_RST  = 32'h0000_0018;

  function automatic logic ctrl_running(input logic [DATA_W-1:0] c);
    return c[B_EN] && (c[B_MODE_L+1:B_MODE_L] == MODE_CONT) &&
           !c[B_ALIGN] && c[B_LPDIS];
  endfunction
endpackage

// File: rtl/pwm_lk_regs.sv
module pwm_lk_regs
  import pwm_lk_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  period_s,
  output logic [CNT_W-1:0]  duty_s,
  output logic [DATA_W-1:0] ctrl_s
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);
  localparam logic [ADDR_W-1:0] A_DUTY   = ADDR_W'(OFF_DUTY);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_s <= '0;
      duty_s   <= '0;
      ctrl_s   <= CTRL_RST;
    end else if (wr) begin
      if (addr == A_PERIOD) period_s <= wdata[CNT_W-1:0];
      if (addr == A_DUTY)   duty_s   <= wdata[CNT_W-1:0];
      if (addr == A_CTRL)   ctrl_s   <= wdata & CTRL_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_COUNT)       rd_mux = DATA_W'(cnt_live);
    else if (addr == A_PERIOD) rd_mux = DATA_W'(period_s);
    else if (addr == A_DUTY)   rd_mux = DATA_W'(duty_s);
    else if (addr == A_CTRL)   rd_mux = ctrl_s;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_lk_timebase.sv
module pwm_lk_timebase #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             lock,
  input  logic [CNT_W-1:0] period_s,
  input  logic [CNT_W-1:0] duty_s,
  input  logic             dpol_s,
  input  logic             ipol_s,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] period_a,
  output logic [CNT_W-1:0] duty_a,
  output logic             dpol_a,
  output logic             ipol_a
);
  logic wrap;
  logic commit;

  assign wrap   = (period_a == '0) || (cnt >= period_a - 1'b1);
  assign commit = (!run || wrap) && !lock;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (!run || wrap) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      period_a <= '0;
      duty_a   <= '0;
      dpol_a   <= 1'b1;
      ipol_a   <= 1'b1;
    end else if (commit) begin
      period_a <= period_s;
      duty_a   <= duty_s;
      dpol_a   <= dpol_s;
      ipol_a   <= ipol_s;
    end
  end
endmodule

// File: rtl/pwm_lk_wave.sv
module pwm_lk_wave #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] period_a,
  input  logic [CNT_W-1:0] duty_a,
  input  logic             dpol_a,
  input  logic             ipol_a,
  output logic             pwm_out
);
  logic level;

  always_comb begin
    if (!run || period_a == '0) level = ipol_a;
    else if (cnt < duty_a)      level = dpol_a;
    else                        level = !dpol_a;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b1;
    else     pwm_out <= level;
  end
endmodule

// File: rtl/pwm_locked_top.sv
module pwm_locked_top
  import pwm_lk_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  logic [CNT_W-1:0]  cnt, period_s, duty_s, period_a, duty_a;
  logic [DATA_W-1:0] ctrl_s;
  logic              run, lock, dpol_a, ipol_a;

  assign run  = ctrl_running(ctrl_s);
  assign lock = ctrl_s[B_LOCK];

  pwm_lk_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .cnt_live(cnt), .rdata(bus_rdata), .period_s(period_s), .duty_s(duty_s),
    .ctrl_s(ctrl_s)
  );

  pwm_lk_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .run(run), .lock(lock), .period_s(period_s),
    .duty_s(duty_s), .dpol_s(ctrl_s[B_DPOL]), .ipol_s(ctrl_s[B_IPOL]),
    .cnt(cnt), .period_a(period_a), .duty_a(duty_a), .dpol_a(dpol_a),
    .ipol_a(ipol_a)
  );

  pwm_lk_wave #(.CNT_W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .run(run), .cnt(cnt), .period_a(period_a),
    .duty_a(duty_a), .dpol_a(dpol_a), .ipol_a(ipol_a), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pwm_lk_checker.sv
module pwm_lk_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             lock,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period_a,
  input logic [CNT_W-1:0] duty_a,
  input logic             dpol_a,
  input logic             ipol_a,
  input logic             pwm_out
);
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (lock && $past(lock)) |-> ($stable(period_a) && $stable(duty_a) && $stable(dpol_a) && $stable(ipol_a))); // R3
  AST_COMMIT_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && (!$stable(period_a) || !$stable(duty_a) || !$stable(dpol_a) || !$stable(ipol_a))) |-> (cnt == '0)); // R4
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (run && period_a != '0) |-> (cnt < period_a)); // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> (pwm_out == $past(ipol_a))); // R8
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R8
  AST_DUTY_NONE: assert property (@(posedge clk) disable iff (rst)
    $past(run && period_a != '0 && duty_a == '0) |-> (pwm_out == !$past(dpol_a))); // R6
  AST_DUTY_FULL: assert property (@(posedge clk) disable iff (rst)
    $past(run && period_a != '0 && duty_a >= period_a) |-> (pwm_out == $past(dpol_a))); // R6
endmodule

bind pwm_locked_top pwm_lk_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .lock(lock), .cnt(cnt),
  .period_a(period_a), .duty_a(duty_a), .dpol_a(dpol_a), .ipol_a(ipol_a),
  .pwm_out(pwm_out)
);

// File: tb/tb_pwm_locked_top.sv
module tb_pwm_locked_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  pwm_locked_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // {period[15:0], duty[15:0], duty_high, idle_high}
  localparam int NV = 11;
  localparam logic [33:0] VEC [0:NV-1] = '{
    {16'd8,  16'd3, 1'b1, 1'b1},
    {16'd5,  16'd0, 1'b1, 1'b1},
    {16'd6,  16'd6, 1'b1, 1'b1},
    {16'd4,  16'd9, 1'b1, 1'b1},
    {16'd10, 16'd7, 1'b0, 1'b1},
    {16'd7,  16'd2, 1'b0, 1'b0},
    {16'd0,  16'd3, 1'b1, 1'b0},
    {16'd0,  16'd3, 1'b1, 1'b1},
    {16'd1,  16'd0, 1'b1, 1'b1},
    {16'd1,  16'd1, 1'b0, 1'b1},
    {16'd3,  16'd1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic highs(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  function automatic logic [31:0] run_ctrl(input logic dp, input logic ip);
    return 32'h103 | (32'(dp) << 3) | (32'(ip) << 4);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h, w, dc, exp_h;
    repeat (4) @(negedge clk);
    check("R1 out during reset", pwm_out, 1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out after reset", pwm_out, 1);
    rd(4'hC, d); check("R1 ctrl reset", d, 32'h18);
    rd(4'h4, d); check("R1 period reset", d, 0);
    rd(4'h8, d); check("R1 duty reset", d, 0);
    rd(4'h0, d); check("R1 count reset", d, 0);

    // R2 readback
    wr(4'h4, 32'h1234); rd(4'h4, d); check("R2 period readback", d, 32'h1234);
    wr(4'h8, 32'h55);   rd(4'h8, d); check("R2 duty readback", d, 32'h55);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, d); check("R2 ctrl mask", d, 32'h17F);
    wr(4'hC, 32'h18);

    // Table walk: R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      int p, du; logic dp, ip;
      p  = int'(VEC[v][33:18]);
      du = int'(VEC[v][17:2]);
      dp = VEC[v][1];
      ip = VEC[v][0];
      wr(4'hC, run_ctrl(dp, ip) & ~32'h1);
      wr(4'h4, 32'(p));
      wr(4'h8, 32'(du));
      wr(4'hC, run_ctrl(dp, ip));
      repeat (2 * p + 4) @(negedge clk);
      if (p == 0) begin
        w = 20;
        exp_h = ip ? w : 0;
      end else begin
        w = 4 * p;
        dc = 4 * ((du < p) ? du : p);
        exp_h = dp ? dc : w - dc;
      end
      highs(w, h);
      check($sformatf("R5/R6/R7 vector %0d high count", v), h, exp_h);
    end

    // R8: any missing run condition -> idle level, count 0
    wr(4'h4, 32'd8); wr(4'h8, 32'd3);
    begin
      logic [31:0] bad [0:4];
      bad = '{32'h10A, 32'h109, 32'h10D, 32'h12B, 32'h00B};
      for (int k = 0; k < 5; k++) begin
        wr(4'hC, 32'h10B);
        repeat (5) @(negedge clk);
        wr(4'hC, bad[k]);
        repeat (3) @(negedge clk);
        highs(16, h);
        check($sformatf("R8 idle level ctrl %0h", bad[k]), h, 0);
        rd(4'h0, d);
        check($sformatf("R8 count held ctrl %0h", bad[k]), d, 0);
      end
    end

    // R5: live count, write to count ignored (period 10)
    wr(4'hC, 32'h10A); wr(4'h4, 32'd10); wr(4'h8, 32'd4); wr(4'hC, 32'h10B);
    repeat (7) @(negedge clk);
    bus_addr = 4'h0;
    @(negedge clk);
    begin
      int prev, cur, bad_steps;
      bad_steps = 0;
      prev = int'(bus_rdata);
      for (int i = 0; i < 14; i++) begin
        if (i == 3) begin bus_wr = 1'b1; bus_wdata = 32'h0; end
        else bus_wr = 1'b0;
        @(negedge clk);
        cur = int'(bus_rdata);
        if (cur != (prev + 1) % 10) bad_steps++;
        prev = cur;
      end
      bus_wr = 1'b0;
      check("R5 count free-runs, write ignored", bad_steps, 0);
    end

    // R3/R4: locked update, atomic commit at wrap
    wr(4'hC, 32'h10A); wr(4'h4, 32'd6); wr(4'h8, 32'd2); wr(4'hC, 32'h10B);
    repeat (10) @(negedge clk);
    wr(4'hC, 32'h14B);
    wr(4'h4, 32'd10); wr(4'h8, 32'd7); wr(4'hC, 32'h15B);
    repeat (9) @(negedge clk);
    highs(24, h);
    check("R3 waveform frozen while locked", h, 8);
    rd(4'h4, d); check("R2/R3 staged period visible", d, 10);
    bus_addr = 4'h0;
    repeat (6) @(negedge clk);
    begin
      int mx; mx = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (int'(bus_rdata) > mx) mx = int'(bus_rdata);
      end
      check("R3 wrap point held while locked", mx, 5);
    end
    wr(4'hC, 32'h11B);
    bus_addr = 4'h0;
    begin
      int prev, cur, nw;
      int pre [0:1];
      pre = '{-1, -1};
      nw = 0;
      @(negedge clk);
      prev = int'(bus_rdata);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        cur = int'(bus_rdata);
        if (cur == 0 && prev != 0 && nw < 2) begin pre[nw] = prev; nw++; end
        prev = cur;
      end
      check("R4 first wrap at old period", pre[0], 5);
      check("R4 second wrap at new period", pre[1], 9);
    end
    highs(40, h);
    check("R4 new duty and polarity active", h, 28);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule